// File: doc/BRIEF.md
# Transmit Frame Checksum Inserter

This block sits on the transmit path between a frame store and a byte serializer. Each frame enters as a length octet followed by the frame body. The low seven bits of the length octet give the body length N in octets. When checksum insertion is switched on in the control register and N is at least 3, the block forwards the length octet and the first N-2 body octets unchanged. While it does so it accumulates a 16-bit CRC over those body octets, and then it appends the two checksum octets itself.

The frame source may end a frame right after the body data. It may also send two extra placeholder octets, which the block consumes and drops. When insertion is off, or the length is too small to hold a checksum, the frame is forwarded unchanged. Both byte streams use a valid/ready handshake and carry an end-of-frame marker. A small register port holds the insertion enable and a 4-bit power field, which is presented to the radio side.

Top module: `fcs_tx_inserter`

## Requirements
- R1: After a synchronous reset, out_valid is 0, tx_pwr is 0 and the control register reads back 0x00.
- R2: A write to address 0x05 stores wdata bit 7 as the insertion enable and bits 3:0 as the power field. A read of 0x05 returns {enable, 3'b000, power} on reg_rdata in the cycle after reg_rd_en. Reads of any other address return 0x00, and writes to any other address change nothing.
- R3: With the enable at 0, the length octet and every following octet appear on the output unchanged and in order, and out_last is set on the octet that carried in_last.
- R4: With the enable at 1 and N (length octet bits 6:0) in the range 3 to 127, the output is the length octet, then body octets 1 to N-2, then CRC bits 7:0, then CRC bits 15:8, and out_last is set only on the last of these. The CRC uses polynomial x^16+x^12+x^5+1 with a start value of 0x0000, and each octet is fed least significant bit first.
- R5: In insertion mode, a frame whose in_last arrives on body octet N-2 produces the full R4 output.
- R6: In insertion mode, a frame that supplies all N body octets has its last two input octets consumed and discarded, and they do not change the output. The next frame is accepted normally.
- R7: With the enable at 1 and N below 3, the frame passes through unchanged as in R3.
- R8: The enable is sampled when the length octet is accepted. A register write during the frame does not change how that frame is handled.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_last hold their values. With backpressure, no octet is lost or repeated.
- R10: The CRC restarts at the start of every frame, so frames sent back to back each get the checksum of their own body.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid one cycle after reg_rd_en |
| tx_pwr | output | 4 | Stored power field |
| in_valid | input | 1 | Input octet valid |
| in_ready | output | 1 | Input octet accepted when high together with in_valid |
| in_data | input | 8 | Input octet (length octet first) |
| in_last | input | 1 | Marks the final input octet of a frame |
| out_valid | output | 1 | Output octet valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output octet |
| out_last | output | 1 | Marks the final output octet of a frame |

## Verification
The hardest case to reach is the drain path. Here the source has delivered placeholder octets, and the block must still emit its two checksum octets while those placeholders wait unconsumed at the input. At the same time, the output may be stalled and a second frame may be queued directly behind. The bench reaches this case by concatenating a full-length frame with a following frame in a single source queue and driving out_ready low on a fixed cycle pattern. It compares the output against a stream built from a bit-serial CRC model, so a lost, repeated or leaked octet breaks the match. A register write is also placed mid-frame to show that the enable is latched at the length octet.

// File: rtl/fcsi_pkg.sv
package fcsi_pkg;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_PASS,
    ST_PAY,
    ST_FCS_LO,
    ST_FCS_HI,
    ST_DRAIN
  } fcsi_state_e;

  localparam int MIN_INS_LEN = 3;
  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;

  // One octet of the reflected CRC, least significant bit first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/fcsi_crc16.sv
module fcsi_crc16 (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import fcsi_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (upd)   crc <= crc16_step(crc, din);
  end
endmodule

// File: rtl/fcsi_regs.sv
module fcsi_regs #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int PWR_W     = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ins_en,
  output logic [PWR_W-1:0]  pwr
);
  localparam int EN_BIT = DATA_W - 1;
  localparam int RSV_W  = DATA_W - 1 - PWR_W;

  logic sel;
  logic unused_rsv_bits;

  assign sel = (addr == CTRL_ADDR);
  assign unused_rsv_bits = ^wdata[EN_BIT-1:PWR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_en <= 1'b0;
      pwr    <= '0;
    end else if (wr_en && sel) begin
      ins_en <= wdata[EN_BIT];
      pwr    <= wdata[PWR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 rdata <= '0;
    else if (rd_en && sel)   rdata <= {ins_en, {RSV_W{1'b0}}, pwr};
    else if (rd_en)          rdata <= '0;
  end
endmodule

// File: rtl/fcsi_out_stage.sv
module fcsi_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_last,
  output logic              can_load,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= push_data;
      out_last  <= push_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fcs_tx_inserter.sv
module fcs_tx_inserter #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 7,
  parameter int ADDR_W = 6,
  parameter int PWR_W  = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [PWR_W-1:0]  tx_pwr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);
  import fcsi_pkg::*;

  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_INS_LEN);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  fcsi_state_e       state;
  logic [LEN_W-1:0]  remain;
  logic              dummy_pend;
  logic              ins_en;
  logic              can_load;
  logic              push;
  logic [DATA_W-1:0] push_data;
  logic              push_last;
  logic              crc_clr;
  logic              crc_upd;
  logic [15:0]       crc;
  logic [LEN_W-1:0]  hdr_len;

  assign hdr_len = in_data[LEN_W-1:0];

  fcsi_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PWR_W(PWR_W), .CTRL_ADDR(CTRL_ADDR)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .ins_en(ins_en), .pwr(tx_pwr)
  );

  fcsi_crc16 crc_i (
    .clk(clk), .rst(rst), .clr(crc_clr), .upd(crc_upd),
    .din(in_data), .crc(crc)
  );

  fcsi_out_stage #(.DATA_W(DATA_W)) ostg_i (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .push_last(push_last), .can_load(can_load), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  always_comb begin
    in_ready  = 1'b0;
    push      = 1'b0;
    push_data = in_data;
    push_last = 1'b0;
    crc_clr   = 1'b0;
    crc_upd   = 1'b0;
    unique case (state)
      ST_HDR: begin
        in_ready  = can_load;
        push      = in_valid && can_load;
        push_last = in_last;
        crc_clr   = push;
      end
      ST_PASS: begin
        in_ready  = can_load;
        push      = in_valid && can_load;
        push_last = in_last;
      end
      ST_PAY: begin
        in_ready  = can_load;
        push      = in_valid && can_load;
        crc_upd   = push;
      end
      ST_FCS_LO: begin
        push      = can_load;
        push_data = crc[7:0];
      end
      ST_FCS_HI: begin
        push      = can_load;
        push_data = crc[15:8];
        push_last = 1'b1;
      end
      ST_DRAIN: begin
        in_ready  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HDR;
      remain     <= '0;
      dummy_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_HDR: if (push && !in_last) begin
          if (ins_en && hdr_len >= LEN_MIN) begin
            state  <= ST_PAY;
            remain <= hdr_len - LEN_W'(2);
          end else begin
            state  <= ST_PASS;
          end
        end
        ST_PASS: if (push && in_last) state <= ST_HDR;
        ST_PAY: if (push) begin
          remain <= remain - LEN_ONE;
          if (remain == LEN_ONE) begin
            state      <= ST_FCS_LO;
            dummy_pend <= !in_last;
          end
        end
        ST_FCS_LO: if (push) state <= ST_FCS_HI;
        ST_FCS_HI: if (push) state <= dummy_pend ? ST_DRAIN : ST_HDR;
        ST_DRAIN: if (in_valid && in_last) state <= ST_HDR;
        default: state <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/fcsi_chk.sv
module fcsi_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int PWR_W  = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h05
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [PWR_W-1:0]  tx_pwr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R2
  pwr_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == CTRL_ADDR) |=> (tx_pwr == $past(reg_wdata[PWR_W-1:0])));

  // R2
  other_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr != CTRL_ADDR) |=> (reg_rdata == '0));
endmodule

bind fcs_tx_inserter fcsi_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PWR_W(PWR_W), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .tx_pwr(tx_pwr), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last)
);

// File: tb/fcs_tx_inserter_tb_top.sv
module fcs_tx_inserter_tb_top;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [3:0] tx_pwr;
  logic       in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid, out_ready = 1'b1, out_last;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] src_q[$];
  bit         src_l[$];
  logic [7:0] exp_q[$];
  bit         exp_l[$];

  always #HALF clk = ~clk;

  fcs_tx_inserter dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pwr(tx_pwr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] b[$]);
    logic [15:0] c = 16'h0000;
    foreach (b[k]) begin
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ b[k][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  // Appends one frame: length octet N, body bytes derived from seed.
  // ins: expect insertion; full: source supplies all N body octets.
  task automatic add_frame(input bit ins, input int n, input bit full, input int seed);
    logic [7:0] body[$];
    logic [7:0] covered[$];
    logic [15:0] c;
    int nsrc;
    for (int i = 0; i < n; i++) body.push_back(8'((seed * 13 + i * 29 + 1) & 255));
    src_q.push_back(8'(n)); src_l.push_back(1'b0);
    exp_q.push_back(8'(n)); exp_l.push_back(1'b0);
    if (ins) begin
      for (int i = 0; i < n - 2; i++) covered.push_back(body[i]);
      c = ref_crc(covered);
      nsrc = full ? n : n - 2;
      for (int i = 0; i < nsrc; i++) begin
        src_q.push_back(body[i]); src_l.push_back(i == nsrc - 1);
      end
      foreach (covered[i]) begin exp_q.push_back(covered[i]); exp_l.push_back(1'b0); end
      exp_q.push_back(c[7:0]);  exp_l.push_back(1'b0);
      exp_q.push_back(c[15:8]); exp_l.push_back(1'b1);
    end else begin
      for (int i = 0; i < n; i++) begin
        src_q.push_back(body[i]); src_l.push_back(i == n - 1);
        exp_q.push_back(body[i]); exp_l.push_back(i == n - 1);
      end
    end
  endtask

  // Streams src_q through the block and compares against exp_q.
  task automatic run_stream(input string req, input int stall_mod,
                            input int chg_cyc, input logic [7:0] chg_val);
    int ii = 0, io = 0, cyc = 0;
    while ((ii < src_q.size() || io < exp_q.size()) && cyc < 5000) begin
      @(negedge clk);
      in_valid  = (ii < src_q.size());
      in_data   = in_valid ? src_q[ii] : 8'h00;
      in_last   = in_valid ? src_l[ii] : 1'b0;
      out_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
      reg_wr_en = (cyc == chg_cyc);
      reg_addr  = 6'h05;
      reg_wdata = chg_val;
      #2;
      if (in_valid && in_ready) ii++;
      if (out_valid && out_ready) begin
        if (io < exp_q.size()) begin
          check(req, {23'd0, out_last, out_data}, {23'd0, exp_l[io], exp_q[io]});
        end else begin
          check({req, " extra octet"}, 32'd1, 32'd0);
        end
        io++;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; reg_wr_en = 1'b0; out_ready = 1'b1;
    check({req, " all input consumed"}, ii, src_q.size());
    check({req, " all output seen"}, io, exp_q.size());
    for (int k = 0; k < 3; k++) begin
      #2;
      check({req, " no extra output"}, {31'd0, out_valid}, 32'd0);
      @(negedge clk);
    end
    src_q.delete(); src_l.delete(); exp_q.delete(); exp_l.delete();
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 tx_pwr", {28'd0, tx_pwr}, 32'd0);
    reg_read(6'h05, d);
    check("R1 ctrl read", {24'd0, d}, 32'd0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    reg_write(6'h05, 8'hFF);
    reg_read(6'h05, d);
    check("R2 reserved read zero", {24'd0, d}, 32'h8F);
    check("R2 tx_pwr", {28'd0, tx_pwr}, 32'hF);
    reg_write(6'h04, 8'h00);
    reg_read(6'h05, d);
    check("R2 other write ignored", {24'd0, d}, 32'h8F);
    reg_read(6'h04, d);
    check("R2 other read zero", {24'd0, d}, 32'h0);
    reg_write(6'h05, 8'h03);
    reg_read(6'h05, d);
    check("R2 enable cleared", {24'd0, d}, 32'h03);
  endtask

  task automatic t_pass();
    reg_write(6'h05, 8'h02);
    add_frame(1'b0, 5, 1'b1, 1);
    run_stream("R3 pass-through", 0, -1, 8'h00);
  endtask

  task automatic t_ins_short();
    reg_write(6'h05, 8'h80);
    add_frame(1'b1, 5, 1'b0, 2);
    run_stream("R4 R5 short source N=5", 0, -1, 8'h00);
    add_frame(1'b1, 3, 1'b0, 3);
    run_stream("R4 minimum N=3", 0, -1, 8'h00);
    add_frame(1'b1, 127, 1'b0, 4);
    run_stream("R4 maximum N=127", 0, -1, 8'h00);
  endtask

  task automatic t_ins_full();
    reg_write(6'h05, 8'h80);
    add_frame(1'b1, 6, 1'b1, 5);
    add_frame(1'b1, 4, 1'b0, 6);
    run_stream("R6 placeholders dropped", 0, -1, 8'h00);
  endtask

  task automatic t_small();
    reg_write(6'h05, 8'h80);
    add_frame(1'b0, 2, 1'b1, 7);
    add_frame(1'b0, 1, 1'b1, 8);
    run_stream("R7 short length passes", 0, -1, 8'h00);
  endtask

  task automatic t_latch();
    reg_write(6'h05, 8'h80);
    add_frame(1'b1, 9, 1'b0, 9);
    run_stream("R8 enable latched at header", 0, 3, 8'h00);
    add_frame(1'b0, 9, 1'b1, 9);
    run_stream("R8 next frame sees disable", 0, -1, 8'h00);
  endtask

  task automatic t_stall();
    reg_write(6'h05, 8'h80);
    add_frame(1'b1, 10, 1'b1, 10);
    add_frame(1'b1, 7, 1'b0, 11);
    run_stream("R9 backpressure", 3, -1, 8'h00);
  endtask

  task automatic t_b2b();
    reg_write(6'h05, 8'h80);
    add_frame(1'b1, 8, 1'b0, 12);
    add_frame(1'b1, 8, 1'b0, 13);
    add_frame(1'b1, 5, 1'b1, 14);
    run_stream("R10 CRC restarts per frame", 2, -1, 8'h00);
  endtask

  initial begin
    #(2 * HALF * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_regs();
    t_pass();
    t_ins_short();
    t_ins_full();
    t_small();
    t_latch();
    t_stall();
    t_b2b();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule